// File: doc/BRIEF.md
# Integer Add/Subtract Carry Unit

This block is the integer addition unit of a processor execute stage. It is purely combinational. It takes two register operands, a raw signed immediate, the stored carry flag, an operation code, an overflow-record bit and a condition-record bit. In the same cycle it returns the result, the carry-out and the signed overflow, each with a write strobe. It also returns a three-bit signed comparison of the result against zero, with its own write strobe.

Every operation goes through one adder. The first adder input is operand A, forced to zero or inverted when the operation needs it. The second input is operand B, the sign-extended immediate, the immediate shifted up by its own width, all ones, or zero. The carry-in is 0, 1 or the stored carry flag. This one path covers the plain, carrying and extended register forms, the minus-one and zero extended forms, negation and the four immediate forms. The execute stage uses the strobes to decide which architectural flags it updates.

Top module: `int_add_unit`

## Requirements
- R1: Op codes 0 (add) and 2 (add, carrying) return A+B. Op codes 1 (subtract-from) and 3 (subtract-from, carrying) return NOT A + B + 1, which is B-A. All results are taken modulo 2^WIDTH.
- R2: Op code 4 returns A + B + caIn. Op code 5 returns NOT A + B + caIn.
- R3: Op code 6 returns A + all-ones + caIn. Op code 7 returns NOT A + all-ones + caIn. Op code 8 returns A + caIn. Op code 9 returns NOT A + caIn. Op code 10 returns NOT A + 1.
- R4: Op code 11 returns A plus the sign-extended immediate. When aIsZeroReg is 1, the value zero is used in place of A.
- R5: Op code 12 returns A plus the immediate, shifted left by IMM_WIDTH bits and then sign-extended. When aIsZeroReg is 1, zero is used in place of A.
- R6: Op code 13 returns A + sign-extended immediate. Op code 14 returns NOT A + sign-extended immediate + 1. Both write the carry flag whatever the state of oe.
- R7: caOut is the carry out of the adder's top bit. caWrite is 1 only for op codes 2 to 9, 13 and 14. When caWrite is 0, caOut is 0.
- R8: ovOut is 1 when the true signed sum of the two adder inputs plus the carry-in lies outside the signed WIDTH-bit range. ovWrite equals oe for op codes 0 to 10 and is 0 for op codes 11 to 14. When ovWrite is 0, ovOut is 0.
- R9: When rc is 1, crWrite is 1 and crField holds {negative, positive, zero} for the signed result: bit 2 is negative, bit 1 is positive and bit 0 is zero. When rc is 0, both crWrite and crField are 0.
- R10: aIsZeroReg has no effect on any op code other than 11 and 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code, with the values listed in R1 to R6 |
| opA | input | WIDTH | Register operand A |
| opB | input | WIDTH | Register operand B |
| imm | input | IMM_WIDTH | Raw signed immediate |
| caIn | input | 1 | Stored carry flag |
| aIsZeroReg | input | 1 | The A register specifier is zero |
| oe | input | 1 | Record overflow |
| rc | input | 1 | Record condition field |
| result | output | WIDTH | Adder result |
| caWrite | output | 1 | Carry flag is to be written |
| caOut | output | 1 | New carry flag value |
| ovWrite | output | 1 | Overflow flag is to be written |
| ovOut | output | 1 | New overflow flag value |
| crWrite | output | 1 | Condition field is to be written |
| crField | output | 3 | {negative, positive, zero} |

## Verification
The unit holds no registers, so every output is due in the same cycle as the inputs that produce it: zero cycles of latency. The bench changes the inputs 2 ns after a rising clock edge and samples all outputs at the next falling edge, when the adder has long since settled. It runs with an 8-bit datapath and a 4-bit immediate. The sweep covers every value of A, every immediate and a spread of B values across all op codes. The expected values come from integer sums of the signed and unsigned operand values.

// File: rtl/int_add_pkg.sv
package int_add_pkg;

  typedef enum logic [3:0] {
    OP_ADD           = 4'd0,
    OP_SUB_FROM      = 4'd1,
    OP_ADD_CARRY     = 4'd2,
    OP_SUB_CARRY     = 4'd3,
    OP_ADD_EXT       = 4'd4,
    OP_SUB_EXT       = 4'd5,
    OP_ADD_M1_EXT    = 4'd6,
    OP_SUB_M1_EXT    = 4'd7,
    OP_ADD_Z_EXT     = 4'd8,
    OP_SUB_Z_EXT     = 4'd9,
    OP_NEGATE        = 4'd10,
    OP_ADD_IMM       = 4'd11,
    OP_ADD_IMM_HI    = 4'd12,
    OP_ADD_IMM_CARRY = 4'd13,
    OP_SUB_IMM_CARRY = 4'd14
  } addOp_e;

  typedef enum logic [2:0] {
    B_REG    = 3'd0,
    B_IMM    = 3'd1,
    B_IMM_HI = 3'd2,
    B_ONES   = 3'd3,
    B_ZERO   = 3'd4
  } bSel_e;

  typedef enum logic [1:0] {
    CIN_ZERO  = 2'd0,
    CIN_ONE   = 2'd1,
    CIN_CARRY = 2'd2
  } cinSel_e;

  typedef struct packed {
    logic    invA;
    logic    zeroA;
    bSel_e   bSel;
    cinSel_e cinSel;
    logic    caWe;
    logic    ovWe;
    logic    crWe;
  } addStrobe_t;

endpackage

// File: rtl/int_add_ctrl.sv
module int_add_ctrl
  import int_add_pkg::*;
(
  input  logic [3:0]  op,
  input  logic        aIsZeroReg,
  input  logic        oe,
  input  logic        rc,
  output addStrobe_t  strobe
);

  logic isImmForm;

  always_comb begin
    strobe        = '0;
    strobe.bSel   = B_REG;
    strobe.cinSel = CIN_ZERO;
    isImmForm     = 1'b0;
    unique case (op)
      OP_ADD: ;
      OP_SUB_FROM: begin
        strobe.invA = 1'b1; strobe.cinSel = CIN_ONE;
      end
      OP_ADD_CARRY: strobe.caWe = 1'b1;
      OP_SUB_CARRY: begin
        strobe.invA = 1'b1; strobe.cinSel = CIN_ONE; strobe.caWe = 1'b1;
      end
      OP_ADD_EXT: begin
        strobe.cinSel = CIN_CARRY; strobe.caWe = 1'b1;
      end
      OP_SUB_EXT: begin
        strobe.invA = 1'b1; strobe.cinSel = CIN_CARRY; strobe.caWe = 1'b1;
      end
      OP_ADD_M1_EXT: begin
        strobe.bSel = B_ONES; strobe.cinSel = CIN_CARRY; strobe.caWe = 1'b1;
      end
      OP_SUB_M1_EXT: begin
        strobe.invA = 1'b1; strobe.bSel = B_ONES;
        strobe.cinSel = CIN_CARRY; strobe.caWe = 1'b1;
      end
      OP_ADD_Z_EXT: begin
        strobe.bSel = B_ZERO; strobe.cinSel = CIN_CARRY; strobe.caWe = 1'b1;
      end
      OP_SUB_Z_EXT: begin
        strobe.invA = 1'b1; strobe.bSel = B_ZERO;
        strobe.cinSel = CIN_CARRY; strobe.caWe = 1'b1;
      end
      OP_NEGATE: begin
        strobe.invA = 1'b1; strobe.bSel = B_ZERO; strobe.cinSel = CIN_ONE;
      end
      OP_ADD_IMM: begin
        isImmForm = 1'b1; strobe.bSel = B_IMM; strobe.zeroA = aIsZeroReg;
      end
      OP_ADD_IMM_HI: begin
        isImmForm = 1'b1; strobe.bSel = B_IMM_HI; strobe.zeroA = aIsZeroReg;
      end
      OP_ADD_IMM_CARRY: begin
        isImmForm = 1'b1; strobe.bSel = B_IMM; strobe.caWe = 1'b1;
      end
      OP_SUB_IMM_CARRY: begin
        isImmForm = 1'b1; strobe.invA = 1'b1; strobe.bSel = B_IMM;
        strobe.cinSel = CIN_ONE; strobe.caWe = 1'b1;
      end
      default: ;
    endcase
    strobe.ovWe = oe & ~isImmForm;
    strobe.crWe = rc;
  end

endmodule

// File: rtl/int_add_datapath.sv
module int_add_datapath
  import int_add_pkg::*;
#(
  parameter int WIDTH     = 64,
  parameter int IMM_WIDTH = 16
) (
  input  addStrobe_t         strobe,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  input  logic [IMM_WIDTH-1:0] imm,
  input  logic               caIn,
  output logic [WIDTH-1:0]   result,
  output logic               caWrite,
  output logic               caOut,
  output logic               ovWrite,
  output logic               ovOut,
  output logic               crWrite,
  output logic [2:0]         crField
);

  localparam int HI_W = 2 * IMM_WIDTH;

  logic [WIDTH-1:0] immExt;
  logic [WIDTH-1:0] immHiExt;
  logic [WIDTH-1:0] aPick;
  logic [WIDTH-1:0] xIn;
  logic [WIDTH-1:0] yIn;
  logic             cinBit;
  logic [WIDTH:0]   sumWide;
  logic             signedOv;

  assign immExt = {{(WIDTH-IMM_WIDTH){imm[IMM_WIDTH-1]}}, imm};

  generate
    if (WIDTH == HI_W) begin : g_hiFull
      assign immHiExt = {imm, {IMM_WIDTH{1'b0}}};
    end else begin : g_hiExt
      assign immHiExt = {{(WIDTH-HI_W){imm[IMM_WIDTH-1]}}, imm, {IMM_WIDTH{1'b0}}};
    end
  endgenerate

  assign aPick = strobe.zeroA ? '0 : opA;
  assign xIn   = strobe.invA ? ~aPick : aPick;

  always_comb begin
    unique case (strobe.bSel)
      B_IMM:    yIn = immExt;
      B_IMM_HI: yIn = immHiExt;
      B_ONES:   yIn = '1;
      B_ZERO:   yIn = '0;
      default:  yIn = opB;
    endcase
    unique case (strobe.cinSel)
      CIN_ONE:   cinBit = 1'b1;
      CIN_CARRY: cinBit = caIn;
      default:   cinBit = 1'b0;
    endcase
  end

  assign sumWide  = {1'b0, xIn} + {1'b0, yIn} + {{WIDTH{1'b0}}, cinBit};
  assign result   = sumWide[WIDTH-1:0];
  assign signedOv = (xIn[WIDTH-1] == yIn[WIDTH-1]) &&
                    (sumWide[WIDTH-1] != xIn[WIDTH-1]);

  assign caWrite = strobe.caWe;
  assign caOut   = strobe.caWe & sumWide[WIDTH];
  assign ovWrite = strobe.ovWe;
  assign ovOut   = strobe.ovWe & signedOv;
  assign crWrite = strobe.crWe;

  always_comb begin
    crField = 3'b000;
    if (strobe.crWe) begin
      if (result[WIDTH-1])   crField = 3'b100;
      else if (result == '0) crField = 3'b001;
      else                   crField = 3'b010;
    end
  end

endmodule

// File: rtl/int_add_unit.sv
module int_add_unit
  import int_add_pkg::*;
#(
  parameter int WIDTH     = 64,
  parameter int IMM_WIDTH = 16
) (
  input  logic [3:0]           op,
  input  logic [WIDTH-1:0]     opA,
  input  logic [WIDTH-1:0]     opB,
  input  logic [IMM_WIDTH-1:0] imm,
  input  logic                 caIn,
  input  logic                 aIsZeroReg,
  input  logic                 oe,
  input  logic                 rc,
  output logic [WIDTH-1:0]     result,
  output logic                 caWrite,
  output logic                 caOut,
  output logic                 ovWrite,
  output logic                 ovOut,
  output logic                 crWrite,
  output logic [2:0]           crField
);

  addStrobe_t strobe;

  int_add_ctrl ctrl_i (
    .op         (op),
    .aIsZeroReg (aIsZeroReg),
    .oe         (oe),
    .rc         (rc),
    .strobe     (strobe)
  );

  int_add_datapath #(
    .WIDTH     (WIDTH),
    .IMM_WIDTH (IMM_WIDTH)
  ) dp_i (
    .strobe  (strobe),
    .opA     (opA),
    .opB     (opB),
    .imm     (imm),
    .caIn    (caIn),
    .result  (result),
    .caWrite (caWrite),
    .caOut   (caOut),
    .ovWrite (ovWrite),
    .ovOut   (ovOut),
    .crWrite (crWrite),
    .crField (crField)
  );

endmodule

// File: rtl/int_add_unit_chk.sv
module int_add_unit_chk
  import int_add_pkg::*;
#(
  parameter int WIDTH     = 64,
  parameter int IMM_WIDTH = 16
) (
  input logic [3:0]           op,
  input logic [WIDTH-1:0]     opA,
  input logic [WIDTH-1:0]     opB,
  input logic [IMM_WIDTH-1:0] imm,
  input logic                 oe,
  input logic                 rc,
  input logic [WIDTH-1:0]     result,
  input logic                 caWrite,
  input logic                 caOut,
  input logic                 ovWrite,
  input logic                 ovOut,
  input logic                 crWrite,
  input logic [2:0]           crField
);

  logic [WIDTH-1:0] plainSum;
  logic [WIDTH-1:0] backSum;

  assign plainSum = opA + opB;
  assign backSum  = result + opA;

  always_comb begin
    if (op == OP_ADD)
      a_r1_add_sum: assert (result == plainSum);
    if (op == OP_SUB_FROM)
      a_r1_sub_from_inverse: assert (backSum == opB);
    if (op == OP_NEGATE)
      a_r3_negate_inverse: assert (backSum == '0);
    if (!caWrite)
      a_r7_carry_quiet: assert (!caOut);
    a_r8_ov_follows_oe: assert (!ovWrite || oe);
    if (!ovWrite)
      a_r8_ov_quiet: assert (!ovOut);
    if (op >= OP_ADD_IMM && op <= OP_SUB_IMM_CARRY)
      a_r8_imm_no_ov: assert (!ovWrite);
    a_r9_cr_follows_rc: assert (crWrite == rc);
    if (crWrite)
      a_r9_cr_onehot: assert ($countones(crField) == 1 &&
                              crField[0] == (result == '0) &&
                              crField[2] == result[WIDTH-1]);
    else
      a_r9_cr_quiet: assert (crField == 3'b000);
  end

endmodule

bind int_add_unit int_add_unit_chk #(
  .WIDTH     (WIDTH),
  .IMM_WIDTH (IMM_WIDTH)
) chk_i (
  .op      (op),
  .opA     (opA),
  .opB     (opB),
  .imm     (imm),
  .oe      (oe),
  .rc      (rc),
  .result  (result),
  .caWrite (caWrite),
  .caOut   (caOut),
  .ovWrite (ovWrite),
  .ovOut   (ovOut),
  .crWrite (crWrite),
  .crField (crField)
);

// File: tb/int_add_unit_tb_top.sv
`timescale 1ns/1ps
module int_add_unit_tb_top;

  localparam int W    = 8;
  localparam int IW   = 4;
  localparam int MASK = (1 << W) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [3:0]   op = '0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [IW-1:0] imm = '0;
  logic caIn = 1'b0, aIsZeroReg = 1'b0, oe = 1'b0, rc = 1'b0;
  logic [W-1:0] result;
  logic caWrite, caOut, ovWrite, ovOut, crWrite;
  logic [2:0] crField;

  int nChecks = 0;
  int nFails  = 0;

  int_add_unit #(.WIDTH(W), .IMM_WIDTH(IW)) dut_i (
    .op(op), .opA(opA), .opB(opB), .imm(imm), .caIn(caIn),
    .aIsZeroReg(aIsZeroReg), .oe(oe), .rc(rc), .result(result),
    .caWrite(caWrite), .caOut(caOut), .ovWrite(ovWrite), .ovOut(ovOut),
    .crWrite(crWrite), .crField(crField)
  );

  task automatic check(input string req, input int act, input int exp, input int opv);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s op=%0d a=%h b=%h imm=%h ca=%0b zr=%0b actual %h expected %h",
               req, opv, opA, opB, imm, caIn, aIsZeroReg, act, exp);
    end
  endtask

  function automatic string resultReq(input int opv, input bit zrv);
    if (zrv && !(opv == 11 || opv == 12)) return "R10";
    if (opv <= 3)  return "R1";
    if (opv <= 5)  return "R2";
    if (opv <= 10) return "R3";
    if (opv == 11) return "R4";
    if (opv == 12) return "R5";
    return "R6";
  endfunction

  task automatic runOne(input int opv, input int av, input int bv, input int iv,
                        input bit cav, input bit zrv, input bit oev, input bit rcv);
    int sa, sb, si, ux, sx, uy, sy, cin, sumU, sT, expRes, expCa, expOv;
    bit inv, caRep, ovRep;
    int expCr;
    @(posedge clk);
    #2;
    op = 4'(opv); opA = W'(av); opB = W'(bv); imm = IW'(iv);
    caIn = cav; aIsZeroReg = zrv; oe = oev; rc = rcv;
    @(negedge clk);
    sa = (av >= 128) ? av - 256 : av;
    sb = (bv >= 128) ? bv - 256 : bv;
    si = (iv >= 8) ? iv - 16 : iv;
    ux = av; sx = sa;
    if ((opv == 11 || opv == 12) && zrv) begin ux = 0; sx = 0; end
    inv = (opv == 1 || opv == 3 || opv == 5 || opv == 7 || opv == 9 ||
           opv == 10 || opv == 14);
    if (inv) begin ux = MASK - ux; sx = -sx - 1; end
    case (opv)
      6, 7:       begin uy = MASK; sy = -1; end
      8, 9, 10:   begin uy = 0; sy = 0; end
      11, 13, 14: begin uy = si & MASK; sy = si; end
      12:         begin uy = (si * 16) & MASK; sy = si * 16; end
      default:    begin uy = bv; sy = sb; end
    endcase
    case (opv)
      1, 3, 10, 14:     cin = 1;
      4, 5, 6, 7, 8, 9: cin = int'(cav);
      default:          cin = 0;
    endcase
    sumU   = ux + uy + cin;
    expRes = sumU & MASK;
    expCa  = (sumU >> W) & 1;
    sT     = sx + sy + cin;
    expOv  = (sT > 127 || sT < -128) ? 1 : 0;
    caRep  = (opv >= 2 && opv <= 9) || opv == 13 || opv == 14;
    ovRep  = oev && opv <= 10;
    if (!rcv)              expCr = 0;
    else if (expRes >= 128) expCr = 4;
    else if (expRes == 0)  expCr = 1;
    else                   expCr = 2;
    check(resultReq(opv, zrv), int'(result), expRes, opv);
    check("R7 carry", int'({caWrite, caOut}), int'({caRep, caRep & expCa[0]}), opv);
    check("R8 overflow", int'({ovWrite, ovOut}), int'({ovRep, ovRep & expOv[0]}), opv);
    check("R9 condition", int'({crWrite, crField}), (rcv ? 8 : 0) + expCr, opv);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin : stimulus
    // idle state: add of zeros with no records: every report strobe low (R7, R8, R9)
    @(negedge clk);
    check("R7 R8 R9 idle", int'({result, caWrite, caOut, ovWrite, ovOut, crWrite, crField}), 0, 0);

    // register, extended and unary forms
    for (int o = 0; o <= 10; o++) begin
      for (int c = 0; c < ((o >= 4 && o <= 9) ? 2 : 1); c++) begin
        for (int a = 0; a < 256; a++) begin
          for (int j = 0; j < 16; j++) begin
            int  b;
            bit  cav;
            b   = (j < 15) ? j * 17 : 128;
            cav = (o >= 4 && o <= 9) ? c[0] : a[4];
            runOne(o, a, b, 0, cav, a[3] ^ j[0], a[0] ^ j[1], a[1] ^ j[2]);
          end
        end
      end
    end

    // immediate forms (R4, R5, R6), zero-register handling (R4, R5, R10)
    for (int o = 11; o <= 14; o++) begin
      for (int a = 0; a < 256; a++) begin
        for (int i = 0; i < 16; i++) begin
          runOne(o, a, a ^ 8'h5A, i, a[5], a[3] ^ i[0], a[0], a[1]);
        end
      end
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule